// File: doc/BRIEF.md
# Branch-Id Indexed Two-Level Local Predictor

This block predicts conditional branch direction from each branch's own past behaviour. A small static branch id names the branch; it is not derived from the fetch address. The id selects a private history register from a directly indexed first-level table. Because the table is indexed directly and carries no tag, two branches never compete for an entry, and a branch's history survives for as long as the block runs. The selected history then addresses a second-level table of 3-bit saturating counters. All ids share that second table. The top bit of the selected counter is the predicted direction.

The block has two request streams. A lookup presents a branch id. One clock later it returns the direction, the history that was used and the counter value that was read. A training request presents a branch id and the resolved outcome. The block first moves the counter addressed by that branch's current history one step toward the outcome. It then shifts the outcome into the history. A lookup and a training request may arrive in the same clock, for the same id or for different ids. The lookup always observes the tables as they stood before that clock's training.

Top module: `lhp_predictor`

## Requirements
- R1: After reset every history is 0 and every counter holds 3. A lookup of any id then returns history 0, counter 3 and direction not-taken. `pred_valid` is low while reset is asserted.
- R2: `pred_valid` is high in exactly those cycles that follow a cycle with `pred_req` high.
- R3: The lookup is done in two steps. `pred_hist` is the stored history of `pred_id`. `pred_ctr` is the counter at the index equal to that history, read as an unsigned number.
- R4: `pred_taken` is bit 2 of the returned counter. It is 1 for counter values 4 to 7 and 0 for values 0 to 3.
- R5: A training request with `upd_taken`=1 increments the counter addressed by the history of `upd_id` as it stood before the request. A counter at 7 stays at 7.
- R6: A training request with `upd_taken`=0 decrements that same counter. A counter at 0 stays at 0.
- R7: After a training request, the history of `upd_id` is the old history shifted one place toward the most significant bit. The outcome enters bit 0 and the old most significant bit is dropped.
- R8: Training one id leaves the history of every other id unchanged, with no eviction however many ids are trained.
- R9: When a lookup and a training request fall in the same cycle, the lookup returns the history and counter from before that training. This holds for the same id as well as for different ids.
- R10: The counter table is shared. Two ids that hold equal histories read and train the same counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_req | input | 1 | Lookup request |
| pred_id | input | ID_W (6) | Branch id to look up |
| upd_req | input | 1 | Training request |
| upd_id | input | ID_W (6) | Branch id to train |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| pred_valid | output | 1 | Lookup result valid |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W (10) | History used for the lookup |
| pred_ctr | output | 3 | Counter value read by the lookup |

## Verification
Lookup and training are the two functions that can meet in one cycle. They collide in two ways: on the same id, or on different ids whose histories address the same counter. The bench provokes both cases on purpose and also mixes them through a long pseudo-random stream of simultaneous requests. It judges each lookup against a model that answers the lookup first and applies the training afterwards. A design that forwards the new value, or that drops a training request in a collision cycle, therefore shows a mismatch in the returned history or counter, or in a later lookup.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
  localparam int CTR_W = 3;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_MIN  = '0;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(3);

  // One saturating step toward the outcome.
  function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] c, input logic up);
    if (up) return (c == CTR_MAX) ? c : c + 1'b1;
    else    return (c == CTR_MIN) ? c : c - 1'b1;
  endfunction

  // Direction carried by a counter.
  function automatic logic ctr_dir(input logic [CTR_W-1:0] c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
  parameter int ID_W   = 6,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   rd_id,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   wr_id,
  input  logic              wr_bit,
  output logic [HIST_W-1:0] wr_hist_old
);
  localparam int N_ID = 1 << ID_W;

  logic [HIST_W-1:0] hist_mem [N_ID];
  logic [HIST_W-1:0] hist_shifted;

  assign rd_hist      = hist_mem[rd_id];
  assign wr_hist_old  = hist_mem[wr_id];
  assign hist_shifted = {wr_hist_old[HIST_W-2:0], wr_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ID; i++) hist_mem[i] <= '0;
    end else if (wr_en) begin
      hist_mem[wr_id] <= hist_shifted;
    end
  end

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (hist_mem[$past(wr_id)][HIST_W-1:1] == $past(wr_hist_old[HIST_W-2:0]))
              && (hist_mem[$past(wr_id)][0] == $past(wr_bit))); // R7

  AST_OTHER_ID_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_id != wr_id) |=> hist_mem[$past(rd_id)] == $past(rd_hist)); // R8
endmodule

// File: rtl/lhp_pattern_table.sv
module lhp_pattern_table
  import lhp_pkg::*;
#(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output logic [CTR_W-1:0]  rd_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_up
);
  localparam int N_CTR = 1 << HIST_W;

  logic [CTR_W-1:0] ctr_mem [N_CTR];
  logic [CTR_W-1:0] ctr_old;
  logic [CTR_W-1:0] ctr_new;

  assign rd_ctr  = ctr_mem[rd_idx];
  assign ctr_old = ctr_mem[wr_idx];
  assign ctr_new = ctr_step(ctr_old, wr_up);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CTR; i++) ctr_mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      ctr_mem[wr_idx] <= ctr_new;
    end
  end

  AST_CTR_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && ctr_old != CTR_MAX) |=>
      ctr_mem[$past(wr_idx)] == CTR_W'($past(ctr_old) + 1'b1)); // R5

  AST_CTR_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && ctr_old == CTR_MAX) |=> ctr_mem[$past(wr_idx)] == CTR_MAX); // R5

  AST_CTR_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && ctr_old != CTR_MIN) |=>
      ctr_mem[$past(wr_idx)] == CTR_W'($past(ctr_old) - 1'b1)); // R6

  AST_CTR_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && ctr_old == CTR_MIN) |=> ctr_mem[$past(wr_idx)] == CTR_MIN); // R6
endmodule

// File: rtl/lhp_predictor.sv
module lhp_predictor
  import lhp_pkg::*;
#(
  parameter int ID_W   = 6,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_req,
  input  logic [ID_W-1:0]   pred_id,
  input  logic              upd_req,
  input  logic [ID_W-1:0]   upd_id,
  input  logic              upd_taken,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  output logic [CTR_W-1:0]  pred_ctr
);
  // Named internal events
  logic [HIST_W-1:0] lkp_hist;
  logic [CTR_W-1:0]  lkp_ctr;
  logic [HIST_W-1:0] trn_hist;
  logic              collide_same_id;

  assign collide_same_id = pred_req && upd_req && (pred_id == upd_id);

  lhp_hist_table #(.ID_W(ID_W), .HIST_W(HIST_W)) u_hist (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_id       (pred_id),
    .rd_hist     (lkp_hist),
    .wr_en       (upd_req),
    .wr_id       (upd_id),
    .wr_bit      (upd_taken),
    .wr_hist_old (trn_hist)
  );

  lhp_pattern_table #(.HIST_W(HIST_W)) u_pat (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (lkp_hist),
    .rd_ctr (lkp_ctr),
    .wr_en  (upd_req),
    .wr_idx (trn_hist),
    .wr_up  (upd_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_hist  <= '0;
      pred_ctr   <= CTR_INIT;
    end else begin
      pred_valid <= pred_req;
      if (pred_req) begin
        pred_hist <= lkp_hist;
        pred_ctr  <= lkp_ctr;
      end
    end
  end

  assign pred_taken = ctr_dir(pred_ctr);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pred_req |=> pred_valid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_req |=> !pred_valid); // R2

  AST_COLLIDE_OLD_HIST: assert property (@(posedge clk) disable iff (!rst_n)
    collide_same_id |=> pred_hist == $past(trn_hist)); // R9
endmodule

// File: tb/lhp_predictor_bench.sv
`timescale 1ns/1ps
module lhp_predictor_bench;
  localparam int ID_W = 6;
  localparam int HW   = 10;
  localparam int NID  = 1 << ID_W;
  localparam int NCTR = 1 << HW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pred_req = 1'b0, upd_req = 1'b0, upd_taken = 1'b0;
  logic [ID_W-1:0] pred_id = '0, upd_id = '0;
  logic pred_valid, pred_taken;
  logic [HW-1:0] pred_hist;
  logic [2:0] pred_ctr;

  always #2 clk = ~clk;

  lhp_predictor #(.ID_W(ID_W), .HIST_W(HW)) u_lhp_predictor (
    .clk(clk), .rst_n(rst_n),
    .pred_req(pred_req), .pred_id(pred_id),
    .upd_req(upd_req), .upd_id(upd_id), .upd_taken(upd_taken),
    .pred_valid(pred_valid), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .pred_ctr(pred_ctr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [HW-1:0] m_hist [NID];
  int            m_ctr  [NCTR];
  logic [31:0]   lfsr = 32'hACE1_2468;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model reads before training, check at next negedge.
  task automatic step(input bit pv, input int pid, input bit uv, input int uid,
                      input bit ut, input string req);
    int e_hist, e_ctr, idx;
    pred_req = pv; pred_id = ID_W'(pid);
    upd_req = uv; upd_id = ID_W'(uid); upd_taken = ut;
    e_hist = int'(m_hist[pid]);
    e_ctr  = m_ctr[e_hist];
    if (uv) begin
      idx = int'(m_hist[uid]);
      if (ut) m_ctr[idx] = (m_ctr[idx] == 7) ? 7 : m_ctr[idx] + 1;
      else    m_ctr[idx] = (m_ctr[idx] == 0) ? 0 : m_ctr[idx] - 1;
      m_hist[uid] = {m_hist[uid][HW-2:0], ut};
    end
    @(negedge clk);
    chk({req, " R2 valid"}, int'(pred_valid), int'(pv));
    if (pv) begin
      chk({req, " R3 hist"}, int'(pred_hist), e_hist);
      chk({req, " R3 ctr"}, int'(pred_ctr), e_ctr);
      chk({req, " R4 dir"}, int'(pred_taken), (e_ctr >= 4) ? 1 : 0);
    end
    pred_req = 1'b0; upd_req = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NID; i++) m_hist[i] = '0;
    for (int i = 0; i < NCTR; i++) m_ctr[i] = 3;
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", int'(pred_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: every id reads history 0, counter 3, not taken
    for (int i = 0; i < NID; i++) step(1, i, 0, 0, 0, "R1 reset sweep");
    // R2: idle cycle gives no valid
    step(0, 0, 0, 0, 0, "R2 idle");
    // R5: taken training on id 7 until its history is all ones and counter saturates
    for (int k = 0; k < HW + 8; k++) step(1, 7, 1, 7, 1, "R5 taken run");
    step(1, 7, 0, 0, 0, "R5 saturated");
    chk("R5 saturated counter", int'(pred_ctr), 7);
    // R6: not-taken training on id 9 drives counter 0 down to its floor
    for (int k = 0; k < 8; k++) step(1, 9, 1, 9, 0, "R6 not-taken run");
    step(1, 9, 0, 0, 0, "R6 floor");
    chk("R6 floor counter", int'(pred_ctr), 0);
    // R8: id 7 history kept after training id 9
    step(1, 7, 0, 0, 0, "R8 untouched id");
    chk("R8 id7 history", int'(pred_hist), NCTR - 1);
    // R7: pattern 1,0,1,1 into id 12
    step(0, 0, 1, 12, 1, "R7 shift");
    step(0, 0, 1, 12, 0, "R7 shift");
    step(0, 0, 1, 12, 1, "R7 shift");
    step(0, 0, 1, 12, 1, "R7 shift");
    step(1, 12, 0, 0, 0, "R7 read");
    chk("R7 history 1011", int'(pred_hist), 11);
    // R9: same-id collision returns pre-training state
    step(1, 12, 1, 12, 0, "R9 same id collide");
    chk("R9 old history", int'(pred_hist), 11);
    step(1, 12, 0, 0, 0, "R9 after collide");
    chk("R9 new history", int'(pred_hist), 22);
    // R10: ids 20 and 21 share counter via equal histories
    step(0, 0, 1, 20, 1, "R10 train 20");
    step(0, 0, 1, 21, 1, "R10 train 21");
    step(1, 20, 1, 21, 1, "R10 shared read");
    // R9/R10 different ids, same counter, same cycle
    step(1, 22, 1, 23, 1, "R9 diff id shared ctr");
    // R7 R8 R9: pseudo-random mixed stream
    for (int k = 0; k < 6000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[3], int'(lfsr[9:4] & 6'h0F), lfsr[2], int'(lfsr[15:10] & 6'h0F),
           lfsr[16] | lfsr[17], "R8 mixed stream");
    end
    // R8: final sweep of all ids against the model
    for (int i = 0; i < NID; i++) step(1, i, 0, 0, 0, "R8 final sweep");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule